// File: doc/BRIEF.md
# Size-Selectable ALU Condition Flags

This block is the flag stage of a two-operand integer ALU. Each operation takes a destination operand and a source operand, works on the low 8, 16 or 32 bits as the size select says, and produces a result in which the bits above the selected size keep the destination's original value. It keeps a five-bit condition register. Four of its bits are negative, zero, overflow and carry. The fifth is an extend bit that follows carry, but only on arithmetic operations.

Carry and overflow come from the most significant bit of the selected size, not from bit 31. On subtraction and negation the carry bit reports a borrow. A five-bit update mask from the instruction decoder decides which flags the current operation may write. Logic operations also never write the extend bit and always clear overflow and carry. Result and flags are registered together on the cycle in which the operation enable is high.

Top module: `szalu_flags`

## Requirements
- R1: While `rst` is high at a clock edge, `result_q` and `flags_q` are cleared to zero on that edge.
- R2: Size codes are 00 = byte (8 bits), 01 = word (16 bits), 10 and 11 = long (32 bits). Result bits above the selected size equal the corresponding `dst_in` bits.
- R3: The flags register is laid out as bit 4 = X (extend), bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. When written, N equals the top bit of the sized result.
- R4: When written, Z is 1 exactly when all bits of the sized result are zero.
- R5: Op 000 is add (dst + src). Its C is the carry out of bit 7, 15 or 31 for byte, word or long.
- R6: Op 001 is subtract (dst - src) and op 110 is negate (0 - dst). For both, C is 1 exactly when a borrow occurs at the selected size.
- R7: For add, subtract and negate, V is 1 exactly when the signed result at the selected size overflows.
- R8: Add, subtract and negate write X with the same value they write to C. Logic operations leave X unchanged.
- R9: Op 010 = AND, 011 = OR, 100 = XOR (dst with src), and 101 = NOT (inverts dst). These ops write N and Z from their result and write V = 0 and C = 0.
- R10: A flag is written only if its bit in `upd_mask` is 1 (same bit order as R3). A flag whose mask bit is 0 keeps its value, while the result still updates.
- R11: When `op_en` is low, neither `result_q` nor `flags_q` changes.
- R12: Op 111 is reserved. It loads `dst_in` unchanged into `result_q` and writes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_en | input | 1 | Perform the operation on this edge |
| op_sel | input | 3 | Operation code (R5, R6, R9, R12) |
| size_sel | input | 2 | Operand size code (R2) |
| upd_mask | input | 5 | Per-flag write enable, X N Z V C order |
| dst_in | input | 32 | Destination operand |
| src_in | input | 32 | Source operand |
| result_q | output | 32 | Registered sized result merged with destination upper bits |
| flags_q | output | 5 | Condition flags X N Z V C |

## Verification
The bench targets carries that leave bit 7 or bit 15 but not bit 31. A design that takes carry from the full-width adder reports C = 0 there and also corrupts the upper bits that should pass through. Overflow cases sit at 0x7F/0x80-style boundaries for every size, and negating the most negative byte must set both V and C. A design that sizes overflow wrongly, or computes the negate borrow the wrong way round, misses one of these. Directed steps run logic operations while X is already set, partial update masks, a deasserted enable and the reserved op. A design that writes X from logic operations, ignores the mask or updates while idle then shows a changed flag.

// File: rtl/szalu_pkg.sv
package szalu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_ALT  = 2'b11
    } size_e;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_AND = 3'b010,
        OP_OR  = 3'b011,
        OP_XOR = 3'b100,
        OP_NOT = 3'b101,
        OP_NEG = 3'b110,
        OP_RSV = 3'b111
    } op_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    localparam int NUM_LANES = 3;

    // lane index: 0 byte, 1 word, 2 long (code 11 folds onto long)
    function automatic logic [1:0] lane_of(input logic [1:0] sz);
        case (sz)
            2'b00:   lane_of = 2'd0;
            2'b01:   lane_of = 2'd1;
            default: lane_of = 2'd2;
        endcase
    endfunction

    function automatic logic is_arith(input logic [2:0] op);
        is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_NEG);
    endfunction

    function automatic logic is_logic(input logic [2:0] op);
        is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOT);
    endfunction

endpackage

// File: rtl/szalu_lane_mask.sv
module szalu_lane_mask
    import szalu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        size_sel,
    output logic [DATA_W-1:0] lane_mask,
    output logic [DATA_W-1:0] msb_onehot
);
    localparam int BYTE_W = DATA_W / 4;
    localparam int WORD_W = DATA_W / 2;

    logic [DATA_W-1:0] byte_mask;
    logic [DATA_W-1:0] word_mask;

    assign byte_mask = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
    assign word_mask = {{(DATA_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};

    always_comb begin
        case (lane_of(size_sel))
            2'd0:    lane_mask = byte_mask;
            2'd1:    lane_mask = word_mask;
            default: lane_mask = {DATA_W{1'b1}};
        endcase
        // top bit of the mask: mask AND NOT (mask >> 1)
        msb_onehot = lane_mask & ~(lane_mask >> 1);
    end
endmodule

// File: rtl/szalu_arith.sv
module szalu_arith
    import szalu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        op_sel,
    input  logic [1:0]        size_sel,
    input  logic [DATA_W-1:0] dst_in,
    input  logic [DATA_W-1:0] src_in,
    output logic [DATA_W-1:0] sum,
    output logic              carry_flag,
    output logic              ovf_flag
);
    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
    logic              cin;
    logic [NUM_LANES-1:0] lane_cout;
    logic [NUM_LANES-1:0] lane_ovf;

    // add: dst + src; sub: dst + ~src + 1; neg: 0 + ~dst + 1
    always_comb begin
        opa = dst_in;
        opb = src_in;
        cin = 1'b0;
        case (op_sel)
            OP_SUB: begin
                opb = ~src_in;
                cin = 1'b1;
            end
            OP_NEG: begin
                opa = '0;
                opb = ~dst_in;
                cin = 1'b1;
            end
            default: ;
        endcase
    end

    assign sum = opa + opb + {{(DATA_W-1){1'b0}}, cin};

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? DATA_W / 4 : (g == 1) ? DATA_W / 2 : DATA_W;
        logic [LW:0] lsum;
        assign lsum = {1'b0, opa[LW-1:0]} + {1'b0, opb[LW-1:0]} + {{LW{1'b0}}, cin};
        assign lane_cout[g] = lsum[LW];
        assign lane_ovf[g]  = (opa[LW-1] == opb[LW-1]) && (lsum[LW-1] != opa[LW-1]);
    end

    logic [1:0] lane;
    logic       cout_sel;
    assign lane     = lane_of(size_sel);
    assign cout_sel = lane_cout[lane];
    assign ovf_flag = lane_ovf[lane];
    // borrow is the inverse of the adder carry on sub and neg
    assign carry_flag = (op_sel == OP_ADD) ? cout_sel : ~cout_sel;
endmodule

// File: rtl/szalu_logic.sv
module szalu_logic
    import szalu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] dst_in,
    input  logic [DATA_W-1:0] src_in,
    output logic [DATA_W-1:0] value
);
    always_comb begin
        case (op_sel)
            OP_AND:  value = dst_in & src_in;
            OP_OR:   value = dst_in | src_in;
            OP_XOR:  value = dst_in ^ src_in;
            OP_NOT:  value = ~dst_in;
            default: value = dst_in;
        endcase
    end
endmodule

// File: rtl/szalu_flag_reg.sv
module szalu_flag_reg
    import szalu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       op_en,
    input  logic [2:0] op_sel,
    input  logic [4:0] upd_mask,
    input  flags_t     next_flags,
    output flags_t     flags
);
    logic [4:0] touch;
    logic [4:0] wr;

    always_comb begin
        if (is_arith(op_sel))      touch = 5'b11111;
        else if (is_logic(op_sel)) touch = 5'b01111;
        else                       touch = 5'b00000;
        wr = touch & upd_mask & {5{op_en}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            for (int i = 0; i < 5; i++) begin
                if (wr[i]) flags[i] <= next_flags[i];
            end
        end
    end
endmodule

// File: rtl/szalu_flags.sv
module szalu_flags
    import szalu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_en,
    input  logic [2:0]        op_sel,
    input  logic [1:0]        size_sel,
    input  logic [4:0]        upd_mask,
    input  logic [DATA_W-1:0] dst_in,
    input  logic [DATA_W-1:0] src_in,
    output logic [DATA_W-1:0] result_q,
    output logic [4:0]        flags_q
);
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] msb_onehot;
    logic [DATA_W-1:0] arith_sum;
    logic [DATA_W-1:0] logic_val;
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] merged;
    logic              a_carry;
    logic              a_ovf;
    flags_t            next_flags;
    flags_t            flags;

    szalu_lane_mask #(.DATA_W(DATA_W)) u_mask (
        .size_sel   (size_sel),
        .lane_mask  (lane_mask),
        .msb_onehot (msb_onehot)
    );

    szalu_arith #(.DATA_W(DATA_W)) u_arith (
        .op_sel     (op_sel),
        .size_sel   (size_sel),
        .dst_in     (dst_in),
        .src_in     (src_in),
        .sum        (arith_sum),
        .carry_flag (a_carry),
        .ovf_flag   (a_ovf)
    );

    szalu_logic #(.DATA_W(DATA_W)) u_logic (
        .op_sel (op_sel),
        .dst_in (dst_in),
        .src_in (src_in),
        .value  (logic_val)
    );

    always_comb begin
        raw    = is_arith(op_sel) ? arith_sum : logic_val;
        merged = (op_sel == OP_RSV) ? dst_in : ((dst_in & ~lane_mask) | (raw & lane_mask));
        next_flags.n = |(merged & msb_onehot);
        next_flags.z = ((merged & lane_mask) == '0);
        next_flags.v = is_arith(op_sel) ? a_ovf : 1'b0;
        next_flags.c = is_arith(op_sel) ? a_carry : 1'b0;
        next_flags.x = a_carry;
    end

    szalu_flag_reg u_flags (
        .clk        (clk),
        .rst        (rst),
        .op_en      (op_en),
        .op_sel     (op_sel),
        .upd_mask   (upd_mask),
        .next_flags (next_flags),
        .flags      (flags)
    );

    always_ff @(posedge clk) begin
        if (rst)        result_q <= '0;
        else if (op_en) result_q <= merged;
    end

    assign flags_q = flags;
endmodule

// File: rtl/szalu_flags_chk.sv
module szalu_flags_chk
    import szalu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              op_en,
    input logic [2:0]        op_sel,
    input logic [1:0]        size_sel,
    input logic [4:0]        upd_mask,
    input logic [DATA_W-1:0] dst_in,
    input logic [DATA_W-1:0] src_in,
    input logic [DATA_W-1:0] result_q,
    input logic [4:0]        flags_q
);
    localparam int BYTE_W = DATA_W / 4;
    localparam int WORD_W = DATA_W / 2;

    logic              ref_seen;
    logic [1:0]        last_size;
    logic              sized_zero;
    logic              sized_top;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_seen  <= 1'b0;
            last_size <= 2'b00;
        end else begin
            ref_seen  <= 1'b1;
            if (op_en) last_size <= size_sel;
        end
    end

    always_comb begin
        case (lane_of(last_size))
            2'd0: begin
                sized_zero = (result_q[BYTE_W-1:0] == '0);
                sized_top  = result_q[BYTE_W-1];
            end
            2'd1: begin
                sized_zero = (result_q[WORD_W-1:0] == '0);
                sized_top  = result_q[WORD_W-1];
            end
            default: begin
                sized_zero = (result_q == '0);
                sized_top  = result_q[DATA_W-1];
            end
        endcase
    end

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_en |=> ($stable(flags_q) && $stable(result_q)));

    // R10
    mask_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op_en && upd_mask == 5'b00000) |=> $stable(flags_q));

    // R8
    logic_keeps_x_chk: assert property (@(posedge clk) disable iff (rst)
        (op_en && is_logic(op_sel)) |=> $stable(flags_q[4]));

    // R9
    logic_clears_vc_chk: assert property (@(posedge clk) disable iff (rst)
        (op_en && is_logic(op_sel) && upd_mask[1] && upd_mask[0]) |=> (flags_q[1:0] == 2'b00));

    // R8
    x_follows_c_chk: assert property (@(posedge clk) disable iff (rst)
        (op_en && is_arith(op_sel) && upd_mask[4] && upd_mask[0]) |=> (flags_q[4] == flags_q[0]));

    // R2
    byte_upper_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (op_en && size_sel == SZ_BYTE) |=> (result_q[DATA_W-1:BYTE_W] == $past(dst_in[DATA_W-1:BYTE_W])));

    // R4
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_seen && op_en && op_sel != OP_RSV && upd_mask[2]) |=> (flags_q[2] == sized_zero));

    // R3
    neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_seen && op_en && op_sel != OP_RSV && upd_mask[3]) |=> (flags_q[3] == sized_top));

    // R12
    reserved_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (op_en && op_sel == OP_RSV) |=> (result_q == $past(dst_in) && $stable(flags_q)));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (result_q == '0 && flags_q == 5'b00000));
endmodule

bind szalu_flags szalu_flags_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_szalu_flags.sv
module test_szalu_flags;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_en;
    logic [2:0]  op_sel;
    logic [1:0]  size_sel;
    logic [4:0]  upd_mask;
    logic [31:0] dst_in;
    logic [31:0] src_in;
    logic [31:0] result_q;
    logic [4:0]  flags_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    szalu_flags i_szalu_flags (
        .clk(clk), .rst(rst), .op_en(op_en), .op_sel(op_sel), .size_sel(size_sel),
        .upd_mask(upd_mask), .dst_in(dst_in), .src_in(src_in),
        .result_q(result_q), .flags_q(flags_q)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  sz;
        logic [31:0] dst;
        logic [31:0] src;
        logic [31:0] res;
        logic [4:0]  flg;
    } vec_t;

    // flags column is X N Z V C, all written (mask 11111)
    localparam vec_t VECS [10] = '{
        '{3'b000, 2'b00, 32'h12345678, 32'h000000FF, 32'h12345677, 5'b10001}, // R5 byte carry
        '{3'b000, 2'b01, 32'h00007FFF, 32'h00000001, 32'h00008000, 5'b01010}, // R7 word ovf
        '{3'b000, 2'b10, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 5'b10101}, // R4 long zero
        '{3'b001, 2'b00, 32'hAABBCC10, 32'h00000020, 32'hAABBCCF0, 5'b11001}, // R6 byte borrow
        '{3'b001, 2'b01, 32'h11118000, 32'h00000001, 32'h11117FFF, 5'b00010}, // R7 word sub ovf
        '{3'b110, 2'b10, 32'h00000000, 32'h00000000, 32'h00000000, 5'b00100}, // R6 neg zero
        '{3'b110, 2'b00, 32'h55555580, 32'h00000000, 32'h55555580, 5'b11011}, // R7 neg min byte
        '{3'b000, 2'b11, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 5'b01010}, // R2 code 11 long
        '{3'b001, 2'b10, 32'h00000005, 32'h00000005, 32'h00000000, 5'b00100}, // R4 equal sub
        '{3'b000, 2'b01, 32'hABCDFFFF, 32'h00000001, 32'hABCD0000, 5'b10101}  // R2 word upper pass
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic run_op(input logic en, input logic [2:0] op, input logic [1:0] sz,
                          input logic [4:0] msk, input logic [31:0] d, input logic [31:0] s);
        @(negedge clk);
        op_en = en; op_sel = op; size_sel = sz; upd_mask = msk; dst_in = d; src_in = s;
        @(negedge clk);
        op_en = 1'b0;
    endtask

    initial begin
        rst = 1'b1; op_en = 1'b0; op_sel = 3'b000; size_sel = 2'b00;
        upd_mask = 5'b00000; dst_in = '0; src_in = '0;
        repeat (3) @(negedge clk);
        check("R1 reset result", result_q, 32'h0);
        check("R1 reset flags", {27'b0, flags_q}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < 10; i++) begin
            run_op(1'b1, VECS[i].op, VECS[i].sz, 5'b11111, VECS[i].dst, VECS[i].src);
            check($sformatf("R2 R5 R6 R7 vec%0d result", i), result_q, VECS[i].res);
            check($sformatf("R3 R4 R5 R6 R7 R8 vec%0d flags", i), {27'b0, flags_q}, {27'b0, VECS[i].flg});
        end

        // flags now X1 N0 Z1 V0 C1
        run_op(1'b1, 3'b010, 2'b00, 5'b11111, 32'h123456F0, 32'h0000008F);
        check("R9 and byte result", result_q, 32'h12345680);
        check("R8 R9 and keeps X", {27'b0, flags_q}, 32'h18);
        run_op(1'b1, 3'b011, 2'b01, 5'b11111, 32'hFFFF0000, 32'h00000000);
        check("R9 or word result", result_q, 32'hFFFF0000);
        check("R4 R9 or word flags", {27'b0, flags_q}, 32'h14);
        run_op(1'b1, 3'b100, 2'b10, 5'b11111, 32'hF0F0F0F0, 32'hFFFFFFFF);
        check("R9 xor long result", result_q, 32'h0F0F0F0F);
        check("R9 xor long flags", {27'b0, flags_q}, 32'h10);
        run_op(1'b1, 3'b101, 2'b00, 5'b11111, 32'hCAFE00FF, 32'h00000000);
        check("R9 not byte result", result_q, 32'hCAFE0000);
        check("R9 not byte flags", {27'b0, flags_q}, 32'h14);

        run_op(1'b1, 3'b000, 2'b10, 5'b00010, 32'h7FFFFFFF, 32'h7FFFFFFF);
        check("R10 V-only result", result_q, 32'hFFFFFFFE);
        check("R10 V-only flags", {27'b0, flags_q}, 32'h16);
        run_op(1'b1, 3'b001, 2'b00, 5'b00000, 32'h00000000, 32'h00000001);
        check("R10 empty mask result", result_q, 32'h000000FF);
        check("R10 empty mask flags", {27'b0, flags_q}, 32'h16);
        run_op(1'b1, 3'b000, 2'b00, 5'b10000, 32'h00000001, 32'h00000001);
        check("R10 X-only result", result_q, 32'h00000002);
        check("R10 R8 X-only flags", {27'b0, flags_q}, 32'h06);

        run_op(1'b0, 3'b000, 2'b10, 5'b11111, 32'hFFFFFFFF, 32'h00000001);
        check("R11 idle result", result_q, 32'h00000002);
        check("R11 idle flags", {27'b0, flags_q}, 32'h06);
        run_op(1'b1, 3'b111, 2'b00, 5'b11111, 32'h13579BDF, 32'h2468ACE0);
        check("R12 reserved result", result_q, 32'h13579BDF);
        check("R12 reserved flags", {27'b0, flags_q}, 32'h06);

        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 late reset result", result_q, 32'h0);
        check("R1 late reset flags", {27'b0, flags_q}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule